// File: doc/BRIEF.md
# Pipelined Synchronous SRAM Core

A synthesizable single-port synchronous static memory of 32-bit words. Address, write data, the three chip selects and the write enables are captured on every rising clock edge. A captured write is committed to the array one edge later. A captured read shows its data on the output one edge later, or, when the static `flowN` pin is held low, in the cycle right after the capture edge with no output register in the path.

Writes come in two strengths. An active-low global write stores the whole word. Below that level, an active-low master byte enable gates four active-low lane enables, so one to four bytes can be written in one cycle. A selected cycle that writes nothing is a read. Three selects allow several devices to share an address bus for depth expansion. The output enable switches the drivers at once, without waiting for a clock edge. A `sleep` input puts the memory into power-down and keeps its contents. A fixed number of clock edges after `sleep` is released pass before new accesses are taken again.

An external burst generator supplies the word address each cycle. Depth is set by `ADDR_W`. The wake-up delay is set by `WAKE_CYCLES`, for example 4 edges for 30 ns at 125 MHz. The default depth is kept small so that elaboration stays light. Setting `ADDR_W` to 16 gives 65536 words.

Top module: `pipe_sram_core`

## Requirements
- R1: While `rstN` is low and in the cycle after reset is released, `rdValid` and `doutEn` are 0 and `dout` is 0.
- R2: An edge takes an access only when `csLowA`=0, `csHigh`=1 and `csLowB`=0. With any other select pattern the edge writes nothing, and no read data follows from it.
- R3: With `globalWrN`=0 on a selected edge, all four bytes of the word are written, whatever `byteMasterN` and `byteWrN` hold.
- R4: With `globalWrN`=1 and `byteMasterN`=0, each lane i with `byteWrN[i]`=0 stores `din[8i+7:8i]`, and the other lanes keep their old value. With `byteMasterN`=1 the lane enables are ignored and the cycle is a read.
- R5: With `flowN`=1, a read captured at edge k drives `rdValid`=1 and the stored word on `dout` during the cycle after edge k+1.
- R6: With `flowN`=0, a read captured at edge k drives `rdValid`=1 and the stored word during the cycle after edge k.
- R7: A write cycle presents no read data. In the output cycle that belongs to it, `rdValid`=0 and `doutEn`=0.
- R8: `outEnN`=1 forces `doutEn`=0 and `dout`=0 at once, without waiting for an edge. `rdValid` is left as it is.
- R9: While `sleep`=1, `rdValid` is 0 and edges take no access. Stored words are kept.
- R10: After `sleep` falls, the first `WAKE_CYCLES` rising edges take no access and `rdValid` stays 0. The edge after them takes an access.
- R11: A read captured on the edge right after a write to the same address returns the newly written word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rstN | input | 1 | Active-low synchronous reset of control state |
| csLowA | input | 1 | Active-low chip select |
| csHigh | input | 1 | Active-high chip select |
| csLowB | input | 1 | Second active-low chip select |
| addr | input | ADDR_W | Word address from the burst generator |
| din | input | 32 | Write data |
| globalWrN | input | 1 | Active-low whole-word write |
| byteMasterN | input | 1 | Active-low gate for the lane enables |
| byteWrN | input | 4 | Active-low per-lane write enables, bit i covers din[8i+7:8i] |
| outEnN | input | 1 | Active-low asynchronous output enable |
| sleep | input | 1 | Power-down request, active high |
| flowN | input | 1 | Static: low selects flow-through output, high selects the pipelined output |
| dout | output | 32 | Read data, 0 when the drivers are off |
| doutEn | output | 1 | Output driver enable (high-impedance when 0) |
| rdValid | output | 1 | Read data valid |

## Verification
The bench builds the core with `ADDR_W`=6 and `WAKE_CYCLES`=3. With 64 words, random traffic confined to a handful of addresses keeps hitting words that were just written, so byte merges and read-after-write cases come up often. It also lets every word be initialised in a few dozen cycles. With a wake delay of three edges, the whole power-down and recovery window, including the edge where accesses resume, fits into short directed sequences. Random sleep bursts then cut into the traffic in both output modes.

// File: rtl/pipe_sram_pkg.sv
package pipe_sram_pkg;
  localparam int LANES  = 4;
  localparam int LANE_W = 8;
  localparam int WORD_W = LANES * LANE_W;

  // Strobes handed from control to datapath, aligned with the input registers.
  typedef struct packed {
    logic             wr;
    logic             rd;
    logic [LANES-1:0] mask;
  } strobe_t;
endpackage

// File: rtl/pipe_sram_ctrl.sv
module pipe_sram_ctrl
  import pipe_sram_pkg::*;
#(
  parameter int WAKE_CYCLES = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             csLowA,
  input  logic             csHigh,
  input  logic             csLowB,
  input  logic             globalWrN,
  input  logic             byteMasterN,
  input  logic [LANES-1:0] byteWrN,
  input  logic             sleep,
  output strobe_t          strobeQ,
  output logic             blocked
);
  localparam int CNT_W = $clog2(WAKE_CYCLES + 2);

  logic [CNT_W-1:0] wakeCnt;
  logic             selected;
  logic [LANES-1:0] laneReq;
  logic [LANES-1:0] writeMask;
  logic             accept;
  strobe_t          strobeNext;

  // Power-down holds off accesses, and so does the wake-up countdown.
  assign blocked  = sleep || (wakeCnt != '0);
  assign selected = !csLowA && csHigh && !csLowB;
  assign accept   = selected && !blocked;

  // Global write wins. Otherwise the master enable gates the lane enables.
  assign laneReq   = byteMasterN ? '0 : ~byteWrN;
  assign writeMask = !globalWrN ? '1 : laneReq;

  always_comb begin
    strobeNext.wr   = accept && (writeMask != '0);
    strobeNext.rd   = accept && (writeMask == '0);
    strobeNext.mask = accept ? writeMask : '0;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      strobeQ <= '0;
      wakeCnt <= '0;
    end else begin
      strobeQ <= strobeNext;
      if (sleep)
        wakeCnt <= CNT_W'(WAKE_CYCLES);
      else if (wakeCnt != '0)
        wakeCnt <= wakeCnt - CNT_W'(1);
    end
  end
endmodule

// File: rtl/pipe_sram_datapath.sv
module pipe_sram_datapath
  import pipe_sram_pkg::*;
#(
  parameter int ADDR_W = 10
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           strobeQ,
  input  logic              blocked,
  input  logic [ADDR_W-1:0] addr,
  input  logic [WORD_W-1:0] din,
  input  logic              flowN,
  input  logic              outEnN,
  output logic [WORD_W-1:0] dout,
  output logic              doutEn,
  output logic              rdValid
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [ADDR_W-1:0] addrQ;
  logic [WORD_W-1:0] dinQ;
  logic [WORD_W-1:0] arrayWord;
  logic [WORD_W-1:0] pipeData;
  logic              pipeValid;
  logic [WORD_W-1:0] presentData;
  logic              presentValid;

  always_ff @(posedge clk) begin
    addrQ <= addr;
    dinQ  <= din;
  end

  // One bank per byte lane; each bank commits the write held in the input registers.
  for (genvar g = 0; g < LANES; g++) begin : gLane
    logic [LANE_W-1:0] bank [DEPTH];

    always_ff @(posedge clk) begin
      if (strobeQ.wr && strobeQ.mask[g])
        bank[addrQ] <= dinQ[g*LANE_W +: LANE_W];
    end

    assign arrayWord[g*LANE_W +: LANE_W] = bank[addrQ];
  end

  // Output register for the pipelined mode.
  always_ff @(posedge clk) begin
    pipeData <= arrayWord;
    if (!rstN)
      pipeValid <= 1'b0;
    else
      pipeValid <= strobeQ.rd;
  end

  // A low flowN bypasses the output register.
  assign presentValid = flowN ? pipeValid : strobeQ.rd;
  assign presentData  = flowN ? pipeData  : arrayWord;

  assign rdValid = presentValid && !blocked;
  assign doutEn  = rdValid && !outEnN;
  assign dout    = doutEn ? presentData : '0;
endmodule

// File: rtl/pipe_sram_core.sv
module pipe_sram_core
  import pipe_sram_pkg::*;
#(
  parameter int ADDR_W      = 10,
  parameter int WAKE_CYCLES = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              csLowA,
  input  logic              csHigh,
  input  logic              csLowB,
  input  logic [ADDR_W-1:0] addr,
  input  logic [31:0]       din,
  input  logic              globalWrN,
  input  logic              byteMasterN,
  input  logic [3:0]        byteWrN,
  input  logic              outEnN,
  input  logic              sleep,
  input  logic              flowN,
  output logic [31:0]       dout,
  output logic              doutEn,
  output logic              rdValid
);
  strobe_t strobeQ;
  logic    blocked;

  pipe_sram_ctrl #(.WAKE_CYCLES(WAKE_CYCLES)) uCtrl (
    .clk         (clk),
    .rstN        (rstN),
    .csLowA      (csLowA),
    .csHigh      (csHigh),
    .csLowB      (csLowB),
    .globalWrN   (globalWrN),
    .byteMasterN (byteMasterN),
    .byteWrN     (byteWrN),
    .sleep       (sleep),
    .strobeQ     (strobeQ),
    .blocked     (blocked)
  );

  pipe_sram_datapath #(.ADDR_W(ADDR_W)) uData (
    .clk     (clk),
    .rstN    (rstN),
    .strobeQ (strobeQ),
    .blocked (blocked),
    .addr    (addr),
    .din     (din),
    .flowN   (flowN),
    .outEnN  (outEnN),
    .dout    (dout),
    .doutEn  (doutEn),
    .rdValid (rdValid)
  );
endmodule

// File: rtl/pipe_sram_checker.sv
module pipe_sram_checker #(
  parameter int WAKE_CYCLES = 4
) (
  input logic        clk,
  input logic        rstN,
  input logic        csLowA,
  input logic        csHigh,
  input logic        csLowB,
  input logic        globalWrN,
  input logic        outEnN,
  input logic        sleep,
  input logic        flowN,
  input logic [31:0] dout,
  input logic        doutEn,
  input logic        rdValid
);
  // Edges seen since sleep was last sampled high (saturating).
  logic [15:0] awakeEdges;

  always_ff @(posedge clk) begin
    if (!rstN)
      awakeEdges <= 16'(WAKE_CYCLES + 1);
    else if (sleep)
      awakeEdges <= '0;
    else if (awakeEdges <= 16'(WAKE_CYCLES))
      awakeEdges <= awakeEdges + 16'd1;
  end

  // R1: reset leaves the outputs quiet
  a_r1_reset_quiet: assert property (@(posedge clk)
    !rstN |=> (!rdValid && !doutEn));

  // R2: a deselected edge yields no flow-through read
  a_r2_deselect_no_read: assert property (@(posedge clk) disable iff (!rstN)
    (!flowN && (csLowA || !csHigh || csLowB)) |=> (!rdValid || flowN));

  // R7: a global write presents no data in flow-through mode
  a_r7_write_no_drive: assert property (@(posedge clk) disable iff (!rstN)
    (!flowN && !globalWrN) |=> (!doutEn || flowN));

  // R8: disabled drivers put nothing on the data pins
  a_r8_oe_gate: assert property (@(posedge clk) disable iff (!rstN)
    outEnN |-> (!doutEn && dout == 32'd0));

  // R9: power-down keeps valid low
  a_r9_sleep_quiet: assert property (@(posedge clk) disable iff (!rstN)
    sleep |-> !rdValid);

  // R10: the wake-up window keeps valid low
  a_r10_wake_quiet: assert property (@(posedge clk) disable iff (!rstN)
    (awakeEdges <= 16'(WAKE_CYCLES)) |-> !rdValid);
endmodule

bind pipe_sram_core pipe_sram_checker #(.WAKE_CYCLES(WAKE_CYCLES)) uChecker (.*);

// File: tb/tb_pipe_sram_core.sv
`timescale 1ns/1ps
module tb_pipe_sram_core;
  localparam int AW    = 6;
  localparam int WAKE  = 3;
  localparam int DEPTH = 1 << AW;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          csLowA = 1'b1, csHigh = 1'b0, csLowB = 1'b1;
  logic [AW-1:0] addr = '0;
  logic [31:0]   din = '0;
  logic          globalWrN = 1'b1, byteMasterN = 1'b1;
  logic [3:0]    byteWrN = 4'hF;
  logic          outEnN = 1'b0, sleep = 1'b0, flowN = 1'b1;
  logic [31:0]   dout;
  logic          doutEn, rdValid;

  int checks = 0;
  int fails  = 0;

  always #4 clk = ~clk;

  pipe_sram_core #(.ADDR_W(AW), .WAKE_CYCLES(WAKE)) dut (.*);

  // Reference state built from the requirements.
  logic [31:0]   refMem [DEPTH];
  bit            sWr, sRd;
  logic [3:0]    sMask;
  logic [AW-1:0] sAddr;
  logic [31:0]   sDin;
  logic [31:0]   pData;
  bit            pValid;
  int            wCnt;

  task automatic chk(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  function automatic logic [31:0] merge(input logic [31:0] old, input logic [31:0] nw, input logic [3:0] m);
    logic [31:0] r = old;
    for (int i = 0; i < 4; i++) if (m[i]) r[i*8 +: 8] = nw[i*8 +: 8];
    return r;
  endfunction

  // One clock: advance the reference at the edge, compare at the next falling edge.
  task automatic cyc(input string tag);
    bit sel, blk, v;
    logic [3:0] m;
    logic [31:0] d;
    @(posedge clk);
    if (sWr) refMem[sAddr] = merge(refMem[sAddr], sDin, sMask);
    pData  = refMem[sAddr];
    pValid = sRd;
    blk = sleep || (wCnt != 0);
    sel = !csLowA && csHigh && !csLowB;
    m   = !globalWrN ? 4'hF : (byteMasterN ? 4'h0 : ~byteWrN);
    sWr = sel && !blk && (m != 0);
    sRd = sel && !blk && (m == 0);
    sMask = m; sAddr = addr; sDin = din;
    if (!rstN) begin sWr = 0; sRd = 0; pValid = 0; wCnt = 0; end
    else if (sleep) wCnt = WAKE;
    else if (wCnt != 0) wCnt--;
    @(negedge clk);
    v = (flowN ? pValid : sRd) && !(sleep || wCnt != 0);
    d = flowN ? pData : refMem[sAddr];
    chk(tag, "rdValid", {31'd0, rdValid}, {31'd0, v});
    chk(tag, "doutEn", {31'd0, doutEn}, {31'd0, v && !outEnN});
    chk(tag, "dout", dout, (v && !outEnN) ? d : 32'd0);
  endtask

  task automatic sel1(input bit on);
    csLowA = !on; csHigh = on; csLowB = !on;
  endtask

  task automatic doWrite(input logic [AW-1:0] a, input logic [31:0] dt, input bit gN, input bit mN,
                         input logic [3:0] bN, input string tag);
    sel1(1); addr = a; din = dt; globalWrN = gN; byteMasterN = mN; byteWrN = bN;
    cyc(tag);
  endtask

  task automatic doRead(input logic [AW-1:0] a, input string tag);
    sel1(1); addr = a; din = $urandom; globalWrN = 1; byteMasterN = 1; byteWrN = 4'hF;
    cyc(tag);
  endtask

  task automatic doIdle(input string tag);
    sel1(0); globalWrN = 1; byteMasterN = 1; byteWrN = 4'hF;
    cyc(tag);
  endtask

  initial begin
    #(8 * 150000);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    sWr = 0; sRd = 0; pValid = 0; wCnt = 0; sAddr = '0; sDin = '0; sMask = '0; pData = '0;
    // R1: reset state
    repeat (3) cyc("R1");
    rstN = 1'b1;
    doIdle("R1");

    // R3: load every word with a whole-word write
    for (int i = 0; i < DEPTH; i++) doWrite(AW'(i), 32'hA5000000 ^ (i * 32'h01030507), 0, 1, 4'hF, "R3");
    doIdle("R3");

    // R3: global write overrides lane enables
    doWrite(6'd5, 32'h11223344, 0, 0, 4'b1010, "R3");
    doRead(6'd5, "R3"); doIdle("R3");
    chk("R3", "global word", dout, 32'h11223344);

    // R4: lanes 1 and 3 only (byteWrN=0101)
    doWrite(6'd5, 32'hDDCCBBAA, 1, 0, 4'b0101, "R4");
    doRead(6'd5, "R4"); doIdle("R4");
    chk("R4", "lane merge", dout, 32'hDD22BB44);
    // R4: master disabled, lane enables ignored
    doWrite(6'd5, 32'h99999999, 1, 1, 4'b0000, "R4");
    doRead(6'd5, "R4"); doIdle("R4");
    chk("R4", "master off", dout, 32'hDD22BB44);

    // R2: each bad select pattern blocks a write
    for (int p = 0; p < 3; p++) begin
      sel1(1); addr = 6'd7; din = 32'hDEAD0000 + p; globalWrN = 0;
      if (p == 0) csLowA = 1; else if (p == 1) csHigh = 0; else csLowB = 1;
      cyc("R2");
    end
    doRead(6'd7, "R2"); doIdle("R2");
    chk("R2", "deselected write", dout, refMem[7]);
    chk("R2", "old word", refMem[7], 32'hA5000000 ^ (7 * 32'h01030507));

    // R11 + R5: write then read the same word, pipelined
    doWrite(6'd9, 32'hCAFEF00D, 0, 1, 4'hF, "R11");
    doRead(6'd9, "R11");
    chk("R5", "one edge later valid", {31'd0, rdValid}, 32'd0);
    doIdle("R5");
    chk("R11", "rd after wr pipelined", dout, 32'hCAFEF00D);
    chk("R5", "valid", {31'd0, rdValid}, 32'd1);

    // R7: writes present nothing
    doWrite(6'd1, 32'h1, 0, 1, 4'hF, "R7");
    doWrite(6'd2, 32'h2, 1, 0, 4'b1110, "R7");
    doIdle("R7");
    chk("R7", "no drive after writes", {31'd0, doutEn}, 32'd0);

    // R8: output enable off during a read
    doRead(6'd9, "R8");
    outEnN = 1; doIdle("R8");
    chk("R8", "valid kept", {31'd0, rdValid}, 32'd1);
    #1 outEnN = 0; #1;
    chk("R8", "async enable", dout, 32'hCAFEF00D);
    @(negedge clk);

    // R6 + R11: flow-through
    flowN = 0; doIdle("R6");
    doWrite(6'd10, 32'h0BADBEEF, 0, 1, 4'hF, "R11");
    doRead(6'd10, "R6");
    chk("R6", "same cycle", dout, 32'h0BADBEEF);
    doIdle("R6");

    // R9: sleep blocks writes, contents kept
    sleep = 1;
    for (int i = 0; i < 4; i++) doWrite(6'd10, 32'h55555555, 0, 1, 4'hF, "R9");
    // R10: wake window
    sleep = 0;
    for (int i = 0; i < WAKE; i++) doWrite(6'd10, 32'h66666666, 0, 1, 4'hF, "R10");
    doRead(6'd10, "R10");
    chk("R10", "kept through sleep", dout, 32'h0BADBEEF);
    doWrite(6'd11, 32'h77777777, 0, 1, 4'hF, "R10");
    doRead(6'd11, "R10");
    chk("R10", "first edge after wake", dout, 32'h77777777);

    // Random traffic in both modes
    for (int ph = 0; ph < 2; ph++) begin
      string tag = ph == 0 ? "R5" : "R6";
      int slp = 0;
      flowN = (ph == 0); doIdle(tag);
      for (int n = 0; n < 2000; n++) begin
        int r = $urandom % 100;
        if (slp > 0) slp--; else if ($urandom % 150 == 0) slp = 1 + $urandom % 4;
        sleep = (slp > 0);
        outEnN = ($urandom % 8 == 0);
        sel1(1); addr = AW'($urandom % 8); din = $urandom;
        globalWrN = 1; byteMasterN = 1; byteWrN = 4'($urandom);
        if (r < 10) sel1(0);
        else if (r < 15) csHigh = 0;
        else if (r < 35) globalWrN = 0;
        else if (r < 60) byteMasterN = 0;
        cyc(tag);
      end
      sleep = 0; outEnN = 0;
      repeat (WAKE + 1) doIdle(tag);
    end

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule